// File: doc/BRIEF.md
# Single-Cycle Stack Datapath

This block is a small processor core that runs a stack program in which every instruction finishes in one clock. Each cycle it fetches one instruction from a byte-wide instruction store and reads the 64-bit register file. An adder moves the stack pointer by one word. The data store is read or written, and all results land together on the next rising edge. Four instructions exist: push a register, pop into a register, do nothing, and stop.

Both stores are loaded through a byte-wide load port while reset is held. After reset is released the core runs from address zero until it reaches a stop instruction or an opcode it does not know. It then freezes and raises `halted`. Any register and any aligned or unaligned 64-bit window of the data store can be read through two combinational probe ports. These are used to inspect results.

Top module: `stack_datapath`

## Requirements
- R1: While `rst_n` is low at a rising edge, `pc` becomes 0 and `halted` becomes 0. Every register becomes 0 except register 4, the stack pointer, which becomes `STACK_RESET` (256 by default).
- R2: Instruction encoding uses the upper nibble of the first byte as the opcode. 0xA is push and 0xB is pop; both are two bytes long, with the register number in the upper nibble of the second byte and the lower nibbles ignored. 0x1 is a one-byte no-op. The PC advances by 2 after push or pop and by 1 after a no-op, one instruction per clock.
- R3: Push lowers the stack pointer by 8. It stores the named register's value as 8 bytes starting at the lowered stack pointer.
- R4: Pop reads 8 bytes starting at the stack pointer value from before the instruction. It writes them to the named register and raises the stack pointer by 8 at the same edge.
- R5: A pop whose destination is register 4 leaves the loaded value in the stack pointer, not the incremented pointer.
- R6: A push of register 4 stores the stack pointer value from before the decrement.
- R7: Register number 15 names no register. It reads as zero, so a push of it stores zero, and a pop into it only moves the stack pointer.
- R8: Opcode 0x0, or any opcode other than 0x0, 0x1, 0xA and 0xB, sets `halted` at the next edge. From then on `pc`, the registers and the data store stay unchanged until reset.
- R9: Words in the data store are little endian: the byte at the lowest address is the least significant. Addresses are taken modulo the store size, so a word may wrap past the top.
- R10: The load port writes a byte only while `rst_n` is low. A load attempted while running changes nothing.
- R11: `probe_reg_val` shows the current contents of register `probe_reg`. `probe_mem_val` shows the little-endian word starting at `probe_addr`. Both are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; also enables loading |
| load_en | input | 1 | Write one byte through the load port (honoured in reset only) |
| load_to_data | input | 1 | 1 selects the data store, 0 the instruction store |
| load_addr | input | DAW | Byte address of the load (instruction store uses the low bits) |
| load_byte | input | 8 | Byte to write |
| pc | output | IAW | Address of the instruction executing this cycle |
| halted | output | 1 | Core has stopped |
| probe_reg | input | 4 | Register number to observe |
| probe_reg_val | output | 64 | Contents of that register |
| probe_addr | input | DAW | Data store byte address to observe |
| probe_mem_val | output | 64 | Little-endian word starting at that address |

## Verification
The bench runs a program whose pops start at a stack pointer that has wrapped past the top of the store. A design that sized addresses wrongly would therefore load the wrong word. Pushes and pops are ordered so that two words swap places. This catches a push that stores at the old pointer or a pop that loads at the new one. The program also pops into the stack pointer, to catch a write priority that lets the increment win, and pushes the stack pointer, to catch a store of the decremented value. It uses register 15 both ways, to catch a design that gives it real storage. A probe at an odd address detects reversed byte order. A second run ends on an unknown opcode, and a load is attempted after the core stops. A design that kept running or let a late load through would show a moved PC or a changed byte.

// File: rtl/spd_pkg.sv
// Shared constants for the stack datapath: word size, register numbering
// and opcode values. Assumes a 4-bit register number field.
package spd_pkg;
    localparam int XLEN       = 64;
    localparam int WORD_BYTES = XLEN / 8;
    localparam int RID_W      = 4;
    localparam int REG_SLOTS  = 1 << RID_W;

    localparam logic [RID_W-1:0] RID_SP   = 4'h4;
    localparam logic [RID_W-1:0] RID_NONE = 4'hF;

    localparam logic [3:0] OPC_STOP = 4'h0;
    localparam logic [3:0] OPC_NOP  = 4'h1;
    localparam logic [3:0] OPC_PUSH = 4'hA;
    localparam logic [3:0] OPC_POP  = 4'hB;
endpackage

// File: rtl/spd_imem.sv
// Instruction store: byte array with one load port and a two-byte fetch
// window starting at the PC. Assumes BYTES is a power of two; the second
// fetched byte wraps to address 0 at the top.
module spd_imem #(
    parameter int BYTES = 64,
    localparam int AW   = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [7:0]    ld_byte,
    input  logic [AW-1:0] fetch_addr,
    output logic [7:0]    byte0,
    output logic [7:0]    byte1
);
    logic [7:0] mem [BYTES];

    // Byte write from the load port.
    always_ff @(posedge clk) begin
        if (ld_en) begin
            mem[ld_addr] <= ld_byte;
        end
    end

    // Fetch window: opcode byte and register byte.
    always_comb begin
        byte0 = mem[fetch_addr];
        byte1 = mem[fetch_addr + AW'(1)];
    end
endmodule

// File: rtl/spd_dmem.sv
// Data store: byte array with little-endian 64-bit access. One word write
// port for the core, one byte load port, and two word read ports (core and
// probe). Assumes BYTES is a power of two; word accesses wrap modulo BYTES.
// A load has priority over a core write in the same cycle.
module spd_dmem
    import spd_pkg::*;
#(
    parameter int BYTES = 256,
    localparam int AW   = $clog2(BYTES)
) (
    input  logic            clk,
    input  logic            ld_en,
    input  logic [AW-1:0]   ld_addr,
    input  logic [7:0]      ld_byte,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [XLEN-1:0] wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [XLEN-1:0] rd_data,
    input  logic [AW-1:0]   pr_addr,
    output logic [XLEN-1:0] pr_data
);
    logic [7:0] mem [BYTES];

    // Byte load, else word store with least significant byte lowest.
    always_ff @(posedge clk) begin
        if (ld_en) begin
            mem[ld_addr] <= ld_byte;
        end else if (wr_en) begin
            for (int k = 0; k < WORD_BYTES; k++) begin
                mem[wr_addr + AW'(k)] <= wr_data[8*k +: 8];
            end
        end
    end

    // Word assembly for both read ports, one byte lane per generate step.
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        assign rd_data[8*g +: 8] = mem[rd_addr + AW'(g)];
        assign pr_data[8*g +: 8] = mem[pr_addr + AW'(g)];
    end
endmodule

// File: rtl/spd_regfile.sv
// Register file: REG_SLOTS-1 real 64-bit registers; number RID_NONE reads
// zero and ignores writes. Three combinational read ports (A, B, probe)
// and two write ports (E, M) that commit at the same edge; M wins when
// both name the same register.
module spd_regfile
    import spd_pkg::*;
#(
    parameter logic [XLEN-1:0] SP_RESET = 64'd256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RID_W-1:0] ra_id,
    output logic [XLEN-1:0]  ra_val,
    input  logic [RID_W-1:0] rb_id,
    output logic [XLEN-1:0]  rb_val,
    input  logic [RID_W-1:0] pr_id,
    output logic [XLEN-1:0]  pr_val,
    input  logic [RID_W-1:0] e_id,
    input  logic [XLEN-1:0]  e_val,
    input  logic [RID_W-1:0] m_id,
    input  logic [XLEN-1:0]  m_val
);
    logic [XLEN-1:0] regs [REG_SLOTS];

    // Reset values, then E write, then M write so M takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_SLOTS; i++) begin
                regs[i] <= (RID_W'(i) == RID_SP) ? SP_RESET : '0;
            end
        end else begin
            if (e_id != RID_NONE) regs[e_id] <= e_val;
            if (m_id != RID_NONE) regs[m_id] <= m_val;
        end
    end

    // Read ports; the "none" number reads zero.
    always_comb begin
        ra_val = (ra_id == RID_NONE) ? '0 : regs[ra_id];
        rb_val = (rb_id == RID_NONE) ? '0 : regs[rb_id];
        pr_val = (pr_id == RID_NONE) ? '0 : regs[pr_id];
    end
endmodule

// File: rtl/stack_datapath.sv
// Single-cycle stack core. Fetch, register read, stack-pointer adder,
// data store access, register writeback and PC update all happen in one
// clock; every write lands at the same rising edge. Assumes IMEM_BYTES and
// DMEM_BYTES are powers of two and IMEM_BYTES <= DMEM_BYTES. Loads are
// accepted only while reset is held.
module stack_datapath
    import spd_pkg::*;
#(
    parameter int              IMEM_BYTES  = 64,
    parameter int              DMEM_BYTES  = 256,
    parameter logic [XLEN-1:0] STACK_RESET = 64'd256,
    localparam int             IAW         = $clog2(IMEM_BYTES),
    localparam int             DAW         = $clog2(DMEM_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             load_to_data,
    input  logic [DAW-1:0]   load_addr,
    input  logic [7:0]       load_byte,
    output logic [IAW-1:0]   pc,
    output logic             halted,
    input  logic [RID_W-1:0] probe_reg,
    output logic [XLEN-1:0]  probe_reg_val,
    input  logic [DAW-1:0]   probe_addr,
    output logic [XLEN-1:0]  probe_mem_val
);
    logic [7:0]       byte0, byte1;
    logic [3:0]       opc;
    logic [RID_W-1:0] reg_a;
    logic             is_push, is_pop, is_nop, run;
    logic [XLEN-1:0]  a_val, sp_val, alu_out, mem_rd;
    logic [RID_W-1:0] rd_a_id, e_id, m_id;
    logic             unused_bits;

    // Fetch.
    spd_imem #(.BYTES(IMEM_BYTES)) u_imem (
        .clk       (clk),
        .ld_en     (load_en && !rst_n && !load_to_data),
        .ld_addr   (load_addr[IAW-1:0]),
        .ld_byte   (load_byte),
        .fetch_addr(pc),
        .byte0     (byte0),
        .byte1     (byte1)
    );

    // Instruction decode from the fetched bytes.
    always_comb begin
        opc     = byte0[7:4];
        reg_a   = byte1[7:4];
        is_push = (opc == OPC_PUSH);
        is_pop  = (opc == OPC_POP);
        is_nop  = (opc == OPC_NOP);
        run     = rst_n && !halted;
        rd_a_id = is_push ? reg_a : RID_NONE;
    end

    // Execute: the stack pointer adder.
    always_comb begin
        alu_out = is_push ? (sp_val - XLEN'(WORD_BYTES)) : (sp_val + XLEN'(WORD_BYTES));
    end

    // Writeback routing: E carries the new stack pointer, M the loaded word.
    always_comb begin
        e_id = (run && (is_push || is_pop)) ? RID_SP : RID_NONE;
        m_id = (run && is_pop) ? reg_a : RID_NONE;
    end

    spd_regfile #(.SP_RESET(STACK_RESET)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_id (rd_a_id),
        .ra_val(a_val),
        .rb_id (RID_SP),
        .rb_val(sp_val),
        .pr_id (probe_reg),
        .pr_val(probe_reg_val),
        .e_id  (e_id),
        .e_val (alu_out),
        .m_id  (m_id),
        .m_val (mem_rd)
    );

    // Memory: push stores at the new pointer, pop loads at the old one.
    spd_dmem #(.BYTES(DMEM_BYTES)) u_dmem (
        .clk    (clk),
        .ld_en  (load_en && !rst_n && load_to_data),
        .ld_addr(load_addr),
        .ld_byte(load_byte),
        .wr_en  (run && is_push),
        .wr_addr(alu_out[DAW-1:0]),
        .wr_data(a_val),
        .rd_addr(sp_val[DAW-1:0]),
        .rd_data(mem_rd),
        .pr_addr(probe_addr),
        .pr_data(probe_mem_val)
    );

    // PC update and stop detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc     <= '0;
            halted <= 1'b0;
        end else if (!halted) begin
            if (is_push || is_pop) begin
                pc <= pc + IAW'(2);
            end else if (is_nop) begin
                pc <= pc + IAW'(1);
            end else begin
                halted <= 1'b1;
            end
        end
    end

    assign unused_bits = ^{byte0[3:0], byte1[3:0]};

    AST_PC_STEP_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && (is_push || is_pop)) |=> (pc == IAW'($past(pc) + IAW'(2)))); // R2
    AST_PUSH_SP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && is_push) |=> (sp_val == $past(sp_val) - 64'd8)); // R3
    AST_POP_SP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && is_pop && reg_a != RID_SP) |=> (sp_val == $past(sp_val) + 64'd8)); // R4
    AST_POP_SP_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && is_pop && reg_a == RID_SP) |=> (sp_val == $past(mem_rd))); // R5
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R8
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(pc) && $stable(sp_val))); // R8
endmodule

// File: tb/tb_stack_datapath.sv
module tb_stack_datapath;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic        load_to_data = 1'b0;
    logic [7:0]  load_addr = '0;
    logic [7:0]  load_byte = '0;
    logic [5:0]  pc;
    logic        halted;
    logic [3:0]  probe_reg = '0;
    logic [63:0] probe_reg_val;
    logic [7:0]  probe_addr = '0;
    logic [63:0] probe_mem_val;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    logic [5:0] exp_pc_q [$];

    localparam logic [63:0] W_A = 64'h1122334455667788;
    localparam logic [63:0] W_B = 64'hCAFEF00D12345678;

    always #10 clk = ~clk;

    stack_datapath dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_to_data(load_to_data),
        .load_addr(load_addr), .load_byte(load_byte), .pc(pc), .halted(halted),
        .probe_reg(probe_reg), .probe_reg_val(probe_reg_val),
        .probe_addr(probe_addr), .probe_mem_val(probe_mem_val)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver side of the scoreboard: expected PC of each executed instruction.
    task automatic expect_pc(input logic [5:0] p);
        exp_pc_q.push_back(p);
    endtask

    task automatic load(input bit to_data, input logic [7:0] a, input logic [7:0] b);
        @(posedge clk); #2;
        load_en = 1'b1; load_to_data = to_data; load_addr = a; load_byte = b;
        @(posedge clk); #2;
        load_en = 1'b0;
    endtask

    task automatic load_word(input logic [7:0] a, input logic [63:0] w);
        for (int k = 0; k < 8; k++) load(1'b1, a + 8'(k), w[8*k +: 8]);
    endtask

    task automatic reg_is(input string req, input logic [3:0] r, input logic [63:0] exp);
        probe_reg = r; #1;
        check(req, probe_reg_val, exp);
    endtask

    task automatic mem_is(input string req, input logic [7:0] a, input logic [63:0] exp);
        probe_addr = a; #1;
        check(req, probe_mem_val, exp);
    endtask

    task automatic wait_halt();
        for (int i = 0; i < 60 && !halted; i++) @(posedge clk);
        #3;
    endtask

    // Monitor side: one executed instruction per clock, compared at negedge.
    always @(negedge clk) begin
        if (mon_on && rst_n && !halted) begin
            checks++;
            if (exp_pc_q.size() == 0) begin
                errors++;
                $display("FAIL R2: actual pc %0d expected no further instruction", pc);
            end else begin
                logic [5:0] e;
                e = exp_pc_q.pop_front();
                if (pc !== e) begin
                    errors++;
                    $display("FAIL R2: actual pc %0d expected %0d", pc, e);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] prog1 [20];
        prog1 = '{8'hB0, 8'h1F, 8'h10, 8'hB0, 8'h20, 8'hA0, 8'h1F, 8'hA0, 8'h2F,
                  8'hA0, 8'h4F, 8'hB0, 8'h3F, 8'hA0, 8'hFF, 8'hB0, 8'hFF,
                  8'hB0, 8'h4F, 8'h00};

        // Run 1: loaded while reset is held.
        repeat (2) @(posedge clk);
        #3;
        check("R1 pc", 64'(pc), 64'd0);
        check("R1 halted", 64'(halted), 64'd0);
        reg_is("R1 sp", 4'd4, 64'd256);
        reg_is("R1 r1", 4'd1, 64'd0);
        for (int i = 0; i < 20; i++) load(1'b0, 8'(i), prog1[i]);
        load_word(8'd0,  W_A);
        load_word(8'd8,  W_B);
        load_word(8'd16, 64'd0);
        load_word(8'd64, 64'd0);
        load_word(8'd248, 64'hFFFF_FFFF_FFFF_FFFF);
        mem_is("R11 probe word", 8'd0, W_A);
        mem_is("R9 wrap probe", 8'd252, {32'h55667788, 32'hFFFFFFFF});
        foreach (prog1[i]) begin end
        expect_pc(6'd0);  expect_pc(6'd2);  expect_pc(6'd3);  expect_pc(6'd5);
        expect_pc(6'd7);  expect_pc(6'd9);  expect_pc(6'd11); expect_pc(6'd13);
        expect_pc(6'd15); expect_pc(6'd17); expect_pc(6'd19);
        @(posedge clk); #2;
        rst_n = 1'b1; mon_on = 1'b1;
        wait_halt();
        check("R8 halted after stop", 64'(halted), 64'd1);
        check("R2 all instructions retired", 64'(exp_pc_q.size()), 64'd0);
        check("R8 pc at stop", 64'(pc), 64'd19);
        reg_is("R4 pop r1 wrapped", 4'd1, W_A);
        reg_is("R2 R4 pop r2 low nibble ignored", 4'd2, W_B);
        reg_is("R6 push sp stored old sp", 4'd3, 64'd256);
        reg_is("R5 pop into sp", 4'd4, W_B);
        reg_is("R7 r15 reads zero", 4'd15, 64'd0);
        mem_is("R3 push r1 at new sp", 8'd8, W_A);
        mem_is("R3 push r2 at new sp", 8'd0, W_B);
        mem_is("R7 push none stored zero", 8'd248, 64'd0);
        mem_is("R9 little endian offset", 8'd9, {8'h00, W_A[63:8]});
        // Late load while running must be ignored; state must stay frozen.
        load(1'b1, 8'd64, 8'hAA);
        repeat (3) @(posedge clk);
        #3;
        mem_is("R10 load ignored when running", 8'd64, 64'd0);
        check("R8 pc frozen", 64'(pc), 64'd19);
        reg_is("R8 sp frozen", 4'd4, W_B);

        // Run 2: unknown opcode stops the core.
        mon_on = 1'b0;
        @(posedge clk); #2;
        rst_n = 1'b0;
        load(1'b0, 8'd0, 8'h10);
        load(1'b0, 8'd1, 8'h10);
        load(1'b0, 8'd2, 8'h70);
        load(1'b0, 8'd3, 8'h10);
        #1;
        reg_is("R1 reset clears r1", 4'd1, 64'd0);
        reg_is("R1 reset restores sp", 4'd4, 64'd256);
        check("R1 halted cleared", 64'(halted), 64'd0);
        expect_pc(6'd0); expect_pc(6'd1); expect_pc(6'd2);
        @(posedge clk); #2;
        rst_n = 1'b1; mon_on = 1'b1;
        wait_halt();
        repeat (3) @(posedge clk);
        #3;
        check("R8 unknown opcode halts", 64'(halted), 64'd1);
        check("R8 pc held at unknown opcode", 64'(pc), 64'd2);
        check("R2 nop steps retired", 64'(exp_pc_q.size()), 64'd0);
        reg_is("R8 sp unchanged", 4'd4, 64'd256);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule